// File: doc/BRIEF.md
# Signature Expansion Invalidation Walker

This block turns a hashed write signature into a sequence of per-line cache actions. On a start pulse it captures the signature, an optional read signature, a local ownership set mask and a mode. The cache-set bitmask is taken from the signature's set-index field. The block then walks only the cache sets whose bit is set, lowest index first. For each set it issues a tag-read request, takes the tag response with the line addresses, valid bits and dirty bits of every way, and tests each line address for membership in the signature. It then emits one action record per visited set, with a per-way invalidate mask and a per-way merge mask.

All three data interfaces are valid/ready streams. A request or action record stays on its pins with valid high until the consumer raises ready. The response is consumed only while the walker raises its own ready. A transfer happens on a rising clock edge where valid and ready are both high. The cache arrays and the word-merge datapath sit outside the block.

The signature is made of LINE_AW/SET_W fields of 2**SET_W bits each. Field k occupies bits [k*2**SET_W +: 2**SET_W] and is a one-hot decode of address bits [k*SET_W +: SET_W]. Field 0 therefore decodes the set index and serves as the set bitmask.

Top module: `sigwalk_expander`

## Requirements
- R1: After a start pulse, set indices are requested in strictly ascending order. Exactly the sets whose bit is set in the walk mask are requested, each once. The walk mask is wr_sig[NS-1:0], or wr_sig[NS-1:0] | rd_sig[NS-1:0] in mode 3.
- R2: If the walk mask is zero at start, done is high in the cycle after the start edge and no set request is made.
- R3: While set_req_valid is high and set_req_ready is low, set_req_valid stays high and set_req_idx stays unchanged.
- R4: A line matches a signature only if, for every field k, the signature bit at offset k*2**SET_W + addr[k*SET_W +: SET_W] is 1. A way whose valid bit is 0 never gets an action.
- R5: Mode 0 (squash): a matching valid line is invalidated only if it is dirty.
- R6: Mode 1 (commit receive): a matching valid line is invalidated only if it is clean. A matching dirty line gets no action.
- R7: Mode 2 (fine grain): a matching clean line is invalidated. A matching dirty line gets the merge flag when its set has a 1 in the local mask, and no action otherwise. It is never invalidated.
- R8: Mode 3 (thread squash with reads): a valid line is invalidated if it matches the read signature, or if it is dirty and matches the write signature.
- R9: Each visited set produces exactly one action record on act_set, act_inval and act_merge. The record is held stable while act_valid is high and act_ready is low. Invalidate and merge are never both set for the same way.
- R10: After reset the block is idle, with busy, done and both valid outputs low. Done is a one-cycle pulse in the cycle after the last action transfer. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| mode | input | 2 | 0 squash, 1 commit receive, 2 fine grain, 3 squash with reads |
| wr_sig | input | SIG_W | Write signature |
| rd_sig | input | SIG_W | Read signature (mode 3) |
| local_mask | input | NS | Sets owned by the local write signature (mode 2) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| set_req_valid | output | 1 | Set index request valid |
| set_req_ready | input | 1 | Cache accepts the request |
| set_req_idx | output | SET_W | Requested set index |
| tag_rsp_valid | input | 1 | Tag response valid |
| tag_rsp_ready | output | 1 | Walker accepts the response |
| tag_rsp_addr | input | WAYS*LINE_AW | Line address of each way |
| tag_rsp_lval | input | WAYS | Line valid of each way |
| tag_rsp_dirty | input | WAYS | Line dirty of each way |
| act_valid | output | 1 | Action record valid |
| act_ready | input | 1 | Consumer accepts the record |
| act_set | output | SET_W | Set the record applies to |
| act_inval | output | WAYS | Ways to invalidate |
| act_merge | output | WAYS | Ways flagged for merge |

## Verification
The walk is driven with sparse set masks, a full mask and an all-zero mask. The sparse and full masks show that only the selected sets are visited, in order. The zero mask separates the immediate-done path from a walk. Every mode runs against the same cache contents, which mix valid, invalid, clean and dirty lines, some inside the signature and some outside it. This shows that the action follows the mode and dirty state, and is not a flat flush. Random back-pressure on the request and action streams and random response delay expose lost or duplicated sets and unstable held values. A start pulse during a walk checks that it leaves the walk unchanged.

// File: rtl/sigwalk_pkg.sv
package sigwalk_pkg;
  typedef enum logic [1:0] {
    WM_SQUASH = 2'd0,
    WM_COMMIT = 2'd1,
    WM_FINE   = 2'd2,
    WM_TLS    = 2'd3
  } walk_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_ACT,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/sigwalk_lowest.sv
module sigwalk_lowest #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/sigwalk_member.sv
module sigwalk_member #(
  parameter  int LINE_AW = 12,
  parameter  int FIELD_W = 4,
  localparam int NF      = LINE_AW / FIELD_W,
  localparam int FS      = 1 << FIELD_W,
  localparam int SIG_W   = NF * FS
) (
  input  logic [SIG_W-1:0]   sig,
  input  logic [LINE_AW-1:0] addr,
  output logic               hit
);
  logic [NF-1:0] fhit;

  for (genvar k = 0; k < NF; k++) begin : g_field
    logic [FS-1:0]      fld;
    logic [FIELD_W-1:0] chunk;
    assign fld     = sig[k*FS +: FS];
    assign chunk   = addr[k*FIELD_W +: FIELD_W];
    assign fhit[k] = fld[chunk];
  end

  assign hit = &fhit;
endmodule

// File: rtl/sigwalk_way_action.sv
module sigwalk_way_action
  import sigwalk_pkg::*;
(
  input  walk_mode_e mode,
  input  logic       lval,
  input  logic       dirty,
  input  logic       wr_hit,
  input  logic       rd_hit,
  input  logic       loc_own,
  output logic       inval,
  output logic       merge
);
  always_comb begin
    inval = 1'b0;
    merge = 1'b0;
    unique case (mode)
      WM_SQUASH: inval = lval & wr_hit & dirty;
      WM_COMMIT: inval = lval & wr_hit & ~dirty;
      WM_FINE: begin
        inval = lval & wr_hit & ~dirty;
        merge = lval & wr_hit & dirty & loc_own;
      end
      WM_TLS:    inval = lval & ((wr_hit & dirty) | rd_hit);
      default: begin
        inval = 1'b0;
        merge = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sigwalk_expander.sv
module sigwalk_expander
  import sigwalk_pkg::*;
#(
  parameter  int LINE_AW = 12,
  parameter  int SET_W   = 4,
  parameter  int WAYS    = 4,
  localparam int NS      = 1 << SET_W,
  localparam int SIG_W   = (LINE_AW / SET_W) * NS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              mode,
  input  logic [SIG_W-1:0]        wr_sig,
  input  logic [SIG_W-1:0]        rd_sig,
  input  logic [NS-1:0]           local_mask,
  output logic                    busy,
  output logic                    done,
  output logic                    set_req_valid,
  input  logic                    set_req_ready,
  output logic [SET_W-1:0]        set_req_idx,
  input  logic                    tag_rsp_valid,
  output logic                    tag_rsp_ready,
  input  logic [WAYS*LINE_AW-1:0] tag_rsp_addr,
  input  logic [WAYS-1:0]         tag_rsp_lval,
  input  logic [WAYS-1:0]         tag_rsp_dirty,
  output logic                    act_valid,
  input  logic                    act_ready,
  output logic [SET_W-1:0]        act_set,
  output logic [WAYS-1:0]         act_inval,
  output logic [WAYS-1:0]         act_merge
);
  walk_state_e        state_q;
  walk_mode_e         mode_q;
  walk_mode_e         mode_in;
  logic [SIG_W-1:0]   wr_q, rd_q;
  logic [NS-1:0]      loc_q;
  logic [NS-1:0]      work_q;
  logic [NS-1:0]      start_mask;
  logic [NS-1:0]      pick_oh;
  logic [SET_W-1:0]   pick_idx;
  logic               pick_any;
  logic [SET_W-1:0]   cur_q;
  logic [WAYS-1:0]    inval_d, merge_d, inval_q, merge_q;
  logic               loc_bit;

  assign mode_in    = walk_mode_e'(mode);
  assign start_mask = (mode_in == WM_TLS) ? (wr_sig[NS-1:0] | rd_sig[NS-1:0])
                                          : wr_sig[NS-1:0];

  sigwalk_lowest #(.N(NS), .IW(SET_W)) u_pick (
    .vec (work_q),
    .idx (pick_idx),
    .any (pick_any)
  );

  assign pick_oh = NS'(1) << pick_idx;
  assign loc_bit = loc_q[cur_q];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_hit, rd_hit;
    sigwalk_member #(.LINE_AW(LINE_AW), .FIELD_W(SET_W)) u_wr_mem (
      .sig  (wr_q),
      .addr (tag_rsp_addr[w*LINE_AW +: LINE_AW]),
      .hit  (wr_hit)
    );
    sigwalk_member #(.LINE_AW(LINE_AW), .FIELD_W(SET_W)) u_rd_mem (
      .sig  (rd_q),
      .addr (tag_rsp_addr[w*LINE_AW +: LINE_AW]),
      .hit  (rd_hit)
    );
    sigwalk_way_action u_act (
      .mode    (mode_q),
      .lval    (tag_rsp_lval[w]),
      .dirty   (tag_rsp_dirty[w]),
      .wr_hit  (wr_hit),
      .rd_hit  (rd_hit),
      .loc_own (loc_bit),
      .inval   (inval_d[w]),
      .merge   (merge_d[w])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= WM_SQUASH;
      wr_q    <= '0;
      rd_q    <= '0;
      loc_q   <= '0;
      work_q  <= '0;
      cur_q   <= '0;
      inval_q <= '0;
      merge_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          mode_q  <= mode_in;
          wr_q    <= wr_sig;
          rd_q    <= (mode_in == WM_TLS) ? rd_sig : '0;
          loc_q   <= local_mask;
          work_q  <= start_mask;
          state_q <= (start_mask == '0) ? ST_DONE : ST_REQ;
        end
        ST_REQ: if (set_req_ready) begin
          cur_q   <= pick_idx;
          work_q  <= work_q & ~pick_oh;
          state_q <= ST_RSP;
        end
        ST_RSP: if (tag_rsp_valid) begin
          inval_q <= inval_d;
          merge_q <= merge_d;
          state_q <= ST_ACT;
        end
        ST_ACT: if (act_ready) begin
          state_q <= (work_q == '0) ? ST_DONE : ST_REQ;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = (state_q == ST_DONE);
  assign set_req_valid = (state_q == ST_REQ) && pick_any;
  assign set_req_idx   = pick_idx;
  assign tag_rsp_ready = (state_q == ST_RSP);
  assign act_valid     = (state_q == ST_ACT);
  assign act_set       = cur_q;
  assign act_inval     = inval_q;
  assign act_merge     = merge_q;

  // Tracking of the previously requested set, used only by the order check.
  logic [SET_W-1:0] prev_idx_q;
  logic             prev_ok_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_idx_q <= '0;
      prev_ok_q  <= 1'b0;
    end else if (state_q == ST_IDLE && start) begin
      prev_ok_q <= 1'b0;
    end else if (set_req_valid && set_req_ready) begin
      prev_idx_q <= set_req_idx;
      prev_ok_q  <= 1'b1;
    end
  end

  // R1
  asc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req_valid && prev_ok_q |-> set_req_idx > prev_idx_q);

  // R2
  empty_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && start_mask == '0) |=> done);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req_valid && !set_req_ready |=> set_req_valid && $stable(set_req_idx));

  // R9
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && !act_ready |=> act_valid && $stable({act_set, act_inval, act_merge}));

  // R9
  act_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> (act_inval & act_merge) == '0);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sigwalk_expander_tb.sv
module sigwalk_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_AW = 12;
  localparam int SET_W   = 4;
  localparam int WAYS    = 4;
  localparam int NS      = 16;
  localparam int NF      = 3;
  localparam int FS      = 16;
  localparam int SIG_W   = 48;

  logic clk, rst_n, start;
  logic [1:0] mode;
  logic [SIG_W-1:0] wr_sig, rd_sig;
  logic [NS-1:0] local_mask;
  logic busy, done, set_req_valid, set_req_ready, tag_rsp_valid, tag_rsp_ready;
  logic [SET_W-1:0] set_req_idx, act_set;
  logic [WAYS*LINE_AW-1:0] tag_rsp_addr;
  logic [WAYS-1:0] tag_rsp_lval, tag_rsp_dirty, act_inval, act_merge;
  logic act_valid, act_ready;

  sigwalk_expander u_dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [LINE_AW-1:0] ctag [NS][WAYS];
  bit cval [NS][WAYS];
  bit cdirty [NS][WAYS];

  int q_idx[$];
  int q_inv[$];
  int q_mrg[$];
  int checks = 0, errors = 0;
  bit walk_done, expect_done, bp_on, seen_reset;
  bit req_fire, rsp_fire;
  logic [SET_W-1:0] req_seen;
  bit prev_req_stall, prev_act_stall, prev_done;
  logic [SET_W-1:0] prev_req_idx;
  logic [SET_W+2*WAYS-1:0] prev_act;
  string cur_tag;

  task automatic chk(bit ok, string rq, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit bmember(logic [SIG_W-1:0] s, logic [LINE_AW-1:0] a);
    for (int k = 0; k < NF; k++) begin
      int pos;
      pos = k * FS + int'(a[k*SET_W +: SET_W]);
      if (s[pos] == 1'b0) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [SIG_W-1:0] sig_put(logic [SIG_W-1:0] s, logic [LINE_AW-1:0] a);
    logic [SIG_W-1:0] r;
    r = s;
    for (int k = 0; k < NF; k++) r[k * FS + int'(a[k*SET_W +: SET_W])] = 1'b1;
    return r;
  endfunction

  task automatic fill_cache();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < WAYS; w++) begin
        ctag[s][w]   = {8'($urandom), 4'(s)};
        cval[s][w]   = ($urandom % 4) != 0;
        cdirty[s][w] = ($urandom % 2) != 0;
      end
  endtask

  function automatic logic [SIG_W-1:0] make_sig(int pct);
    logic [SIG_W-1:0] s;
    s = '0;
    for (int st = 0; st < NS; st++)
      for (int w = 0; w < WAYS; w++)
        if (($urandom % 100) < pct) s = sig_put(s, ctag[st][w]);
    s = sig_put(s, 12'($urandom));
    return s;
  endfunction

  task automatic build_expect(int md, logic [SIG_W-1:0] wr, logic [SIG_W-1:0] rd, logic [NS-1:0] loc);
    logic [NS-1:0] msk;
    msk = wr[NS-1:0] | ((md == 3) ? rd[NS-1:0] : '0);
    for (int s = 0; s < NS; s++) begin
      if (msk[s]) begin
        int inv, mrg;
        inv = 0; mrg = 0;
        for (int w = 0; w < WAYS; w++) begin
          bit mw, mr, v, d, i, m;
          mw = bmember(wr, ctag[s][w]);
          mr = bmember(rd, ctag[s][w]);
          v = cval[s][w]; d = cdirty[s][w];
          i = 0; m = 0;
          case (md)
            0: i = v && mw && d;
            1: i = v && mw && !d;
            2: begin i = v && mw && !d; m = v && mw && d && loc[s]; end
            default: i = v && ((mw && d) || mr);
          endcase
          if (i) inv |= (1 << w);
          if (m) mrg |= (1 << w);
        end
        q_idx.push_back(s); q_inv.push_back(inv); q_mrg.push_back(mrg);
      end
    end
  endtask

  // Monitor: samples at the falling edge, compares with the model queues.
  initial begin
    forever begin
      @(negedge clk);
      req_fire = set_req_valid && set_req_ready;
      rsp_fire = tag_rsp_valid && tag_rsp_ready;
      if (seen_reset && rst_n) begin
        if (prev_req_stall)
          chk(set_req_valid && set_req_idx == prev_req_idx, "R3 held request", longint'(set_req_idx), longint'(prev_req_idx));
        if (prev_act_stall)
          chk(act_valid && {act_set, act_inval, act_merge} == prev_act, "R9 held action",
              longint'({act_set, act_inval, act_merge}), longint'(prev_act));
        if (req_fire) begin
          if (q_idx.size() == 0) chk(0, {"R1 unexpected set ", cur_tag}, longint'(set_req_idx), -1);
          else chk(set_req_idx == SET_W'(q_idx[0]), {"R1 set order ", cur_tag}, longint'(set_req_idx), longint'(q_idx[0]));
          req_seen = set_req_idx;
        end
        if (act_valid && act_ready) begin
          if (q_idx.size() == 0) chk(0, {"R9 unexpected action ", cur_tag}, longint'(act_set), -1);
          else begin
            chk(act_set == SET_W'(q_idx[0]) && act_inval == WAYS'(q_inv[0]) && act_merge == WAYS'(q_mrg[0]),
                {"R4 R5 R6 R7 R8 action ", cur_tag},
                longint'({act_set, act_inval, act_merge}),
                longint'({SET_W'(q_idx[0]), WAYS'(q_inv[0]), WAYS'(q_mrg[0])}));
            void'(q_idx.pop_front()); void'(q_inv.pop_front()); void'(q_mrg.pop_front());
          end
        end
        if (done) begin
          chk(expect_done && q_idx.size() == 0 && !prev_done, {"R10 done ", cur_tag},
              longint'(q_idx.size()), 0);
          expect_done = 0;
          walk_done = 1;
        end
      end
      prev_req_stall = set_req_valid && !set_req_ready;
      prev_req_idx   = set_req_idx;
      prev_act_stall = act_valid && !act_ready;
      prev_act       = {act_set, act_inval, act_merge};
      prev_done      = done;
    end
  end

  // Driver for ready signals and the tag response, just after each rising edge.
  initial begin
    bit pend;
    int dly;
    logic [SET_W-1:0] pset;
    pend = 0; dly = 0; pset = '0;
    forever begin
      @(posedge clk); #1;
      if (tag_rsp_valid && rsp_fire) tag_rsp_valid = 0;
      if (req_fire) begin
        pend = 1; pset = req_seen; dly = bp_on ? int'($urandom % 3) : 0;
        req_fire = 0;
      end
      if (pend && !tag_rsp_valid) begin
        if (dly == 0) begin
          for (int w = 0; w < WAYS; w++) begin
            tag_rsp_addr[w*LINE_AW +: LINE_AW] = ctag[pset][w];
            tag_rsp_lval[w]  = cval[pset][w];
            tag_rsp_dirty[w] = cdirty[pset][w];
          end
          tag_rsp_valid = 1; pend = 0;
        end else dly--;
      end
      set_req_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
      act_ready     = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic run_walk(int md, logic [SIG_W-1:0] wr, logic [SIG_W-1:0] rd,
                          logic [NS-1:0] loc, bit poke, string tag);
    bit zero;
    cur_tag = tag;
    build_expect(md, wr, rd, loc);
    zero = (q_idx.size() == 0);
    walk_done = 0; expect_done = 1;
    @(posedge clk); #1;
    start = 1; mode = 2'(md); wr_sig = wr; rd_sig = rd; local_mask = loc;
    @(posedge clk); #1;
    start = 0;
    if (zero) begin
      @(negedge clk);
      chk(done == 1'b1, {"R2 immediate done ", tag}, longint'(done), 1);
    end
    if (poke) begin
      @(posedge clk); #1;
      start = 1; mode = 2'd3; wr_sig = '1; rd_sig = '1; local_mask = '1;
      @(posedge clk); #1;
      start = 0;
    end
    while (!walk_done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !set_req_valid && !act_valid, {"R10 idle after walk ", tag},
        longint'({busy, done, set_req_valid, act_valid}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: walk did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; mode = 0; wr_sig = '0; rd_sig = '0; local_mask = '0;
    tag_rsp_valid = 0; tag_rsp_addr = '0; tag_rsp_lval = '0; tag_rsp_dirty = '0;
    set_req_ready = 1; act_ready = 1; bp_on = 0; seen_reset = 0; cur_tag = "reset";
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    seen_reset = 1;
    @(negedge clk);
    chk(!busy && !done && !set_req_valid && !act_valid, "R10 reset state",
        longint'({busy, done, set_req_valid, act_valid}), 0);

    fill_cache();
    run_walk(0, make_sig(30), '0, '0, 0, "squash");
    bp_on = 1;
    run_walk(1, make_sig(30), '0, '0, 0, "commit bp");
    run_walk(2, make_sig(40), '0, 16'($urandom), 0, "fine bp");
    run_walk(2, make_sig(40), '0, '1, 0, "fine all local");
    run_walk(3, make_sig(20), make_sig(20), '0, 0, "tls squash");
    begin
      logic [SIG_W-1:0] z;
      z = make_sig(30);
      z[NS-1:0] = '0;
      bp_on = 0;
      run_walk(1, z, '0, '0, 0, "zero mask");
      run_walk(3, z, {32'($urandom), 16'h0}, '0, 0, "zero mask tls");
    end
    begin
      logic [SIG_W-1:0] f;
      f = '1;
      bp_on = 1;
      run_walk(0, f, '0, '0, 1, "full mask poke");
      run_walk(1, f, '0, '0, 0, "full mask commit");
    end
    for (int it = 0; it < 10; it++) begin
      fill_cache();
      bp_on = (it % 2) == 1;
      run_walk(it % 4, make_sig(15 + it * 4), make_sig(10), 16'($urandom), it == 5, "random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule